// File: doc/BRIEF.md
# Calendar Update and Alarm Engine

This block keeps wall-clock time and a calendar in seven byte registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. On every one-second tick it advances them by one second and carries the overflow through to the next larger field. The bytes are held either as plain binary or as two packed decimal digits. Hours are held either as 0 to 23 or as 1 to 12 with a PM marker. An optional daylight-saving mode moves the clock forward one hour in spring and back one hour in autumn.

Two copies of the time are kept. The working copy advances on every tick. The visible copy is the one that reads return. It takes the new working value on each tick, except while the hold input is high; then it keeps its value and the working copy goes on counting. A register write lands in both copies at once. Three alarm bytes, for seconds, minutes and hours, are compared with the new time on each transfer. A byte whose two top bits are both set matches any value. The block gives a one-cycle update pulse on each transfer, and a one-cycle alarm pulse in the same cycle when all three alarm bytes match.

Top module: `rtc_cal_engine`

## Requirements
- R1: With `bin_mode_i`=1, every byte holds its plain binary value. A tick carries 59 seconds into the minutes, 59 minutes into the hours, and the last hour into the day fields.
- R2: With `bin_mode_i`=0, every byte holds two decimal digits, tens in bits 7:4 and units in bits 3:0. The same carries apply as in R1 (for example, seconds 0x59 are followed by 0x00).
- R3: With `hour24_i`=0, the hour byte runs 1 to 12 and bit 7 set marks PM. After 11:59:59 AM comes 12:00:00 with PM set. After 12:59:59 comes 1:00:00 with the PM bit unchanged. After 11:59:59 PM comes 12:00:00 AM, and the day advances.
- R4: With `hour24_i`=1, the hour byte runs 0 to 23, and 23:59:59 is followed by 00:00:00 of the next day.
- R5: Months have 31 days, except April, June, September and November with 30, and February with 29 when the year is a multiple of 4 and 28 otherwise. After the last day of a month comes day 1 of the next month. After December comes January, and the year advances modulo 100.
- R6: The weekday runs 1 to 7, with 1 meaning Sunday, and 7 is followed by 1 when the day advances.
- R7: While `set_i`=1, ticks leave the visible copy unchanged and give no pulses, but the working copy still advances. The first tick after `set_i` returns to 0 shows the working time, which includes every tick taken during the hold.
- R8: Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours. Other addresses read 0. A write lands in both copies of the time. Bit 7 of the seconds byte is always stored and read as 0.
- R9: `alarm_o` pulses together with `update_o` when each of the three alarm bytes either equals the new time byte or has bits 7:6 = 11. Otherwise it stays low.
- R10: `update_o` is high for exactly the one cycle that follows each clock edge that samples `tick_i`=1 with `set_i`=0.
- R11: With `dst_en_i`=1, on a Sunday in April with day of month 1 to 7, 1:59:59 AM is followed by 3:00:00 AM. With `dst_en_i`=0, it is followed by 2:00:00.
- R12: With `dst_en_i`=1, on a Sunday in October in the last seven days of the month, the first time 1:59:59 AM is reached it is followed by 1:00:00. The next time 1:59:59 is reached it is followed by 2:00:00. The step back can only happen again after the hour has gone past 1.
- R13: After reset the time reads 00:00:00, weekday 1, day 1, month 1, year 0, all alarm bytes read 0, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| set_i | input | 1 | Hold: freezes the visible copy |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = packed decimal |
| hour24_i | input | 1 | 1 = 24-hour format, 0 = 12-hour format with PM in bit 7 |
| dst_en_i | input | 1 | Enables the daylight-saving steps |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data from the visible copy or the alarm bytes, combinational |
| alarm_o | output | 1 | Alarm match pulse |
| update_o | output | 1 | Update-ended pulse |

## Verification
A tick driven in one cycle is taken at the next rising edge. At the following falling edge the bench checks both pulses and reads all seven time bytes back through the combinational read port, before any further edge. Writes also complete at one edge and are read back on the falling edge after it. `update_o` is checked once more one cycle later to prove it has dropped. Every expected byte comes from a bench-side model that counts in plain integers and encodes according to the selected mode.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [6:0] dec_val(input logic [7:0] v, input logic bin);
    int t;
    t = bin ? int'(v[6:0]) : int'(v[7:4]) * 10 + int'(v[3:0]);
    return 7'(t);
  endfunction

  function automatic logic [7:0] enc_val(input logic [6:0] n, input logic bin);
    int t;
    t = int'(n);
    return bin ? {1'b0, n} : {4'(t / 10), 4'(t % 10)};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [6:0] yr);
    if (mo == 7'd2) return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
    if (mo == 7'd4 || mo == 7'd6 || mo == 7'd9 || mo == 7'd11) return 7'd30;
    return 7'd31;
  endfunction

  function automatic logic [6:0] hour_to24(input logic [7:0] hb, input logic bin, input logic h24);
    logic [6:0] v;
    v = dec_val({1'b0, hb[6:0]}, bin);
    if (h24) return v;
    if (v == 7'd12) return hb[7] ? 7'd12 : 7'd0;
    return v + (hb[7] ? 7'd12 : 7'd0);
  endfunction

  function automatic logic [7:0] hour_from24(input logic [6:0] h, input logic bin, input logic h24);
    logic [6:0] h12;
    logic [7:0] e;
    logic pm;
    if (h24) return enc_val(h, bin);
    pm  = (h >= 7'd12);
    h12 = pm ? h - 7'd12 : h;
    if (h12 == 7'd0) h12 = 7'd12;
    e = enc_val(h12, bin);
    return {pm, e[6:0]};
  endfunction

endpackage

// File: rtl/rtc_cal_next.sv
`timescale 1ns/1ps
module rtc_cal_next
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_SPAN  = 100,
  parameter int SPRING_MON = 4,
  parameter int FALL_MON   = 10,
  parameter int SUNDAY     = 1,
  parameter int DST_HOUR   = 1
) (
  input  cal_t cur_i,
  input  logic bin_i,
  input  logic h24_i,
  input  logic dse_i,
  input  logic fb_done_i,
  output cal_t nxt_o,
  output logic fb_set_o,
  output logic fb_clr_o
);
  localparam logic [6:0] LAST_YEAR = 7'(YEAR_SPAN - 1);
  localparam logic [6:0] SPR_M     = 7'(SPRING_MON);
  localparam logic [6:0] FALL_M    = 7'(FALL_MON);
  localparam logic [6:0] SUN_D     = 7'(SUNDAY);
  localparam logic [6:0] DST_H     = 7'(DST_HOUR);

  logic [6:0] s, m, h, w, d, mo, y, mlen;
  logic at_edge, spring, fall, day_c;

  always_comb begin
    s    = dec_val(cur_i.sec, bin_i);
    m    = dec_val(cur_i.min, bin_i);
    h    = hour_to24(cur_i.hour, bin_i, h24_i);
    w    = dec_val(cur_i.dow, bin_i);
    d    = dec_val(cur_i.date, bin_i);
    mo   = dec_val(cur_i.mon, bin_i);
    y    = dec_val(cur_i.year, bin_i);
    mlen = month_len(mo, y);
    at_edge = (h == DST_H) && (m == 7'd59) && (s == 7'd59);
    spring  = dse_i && (mo == SPR_M) && (w == SUN_D) && (d <= 7'd7) && at_edge;
    // last week of the month: one more week would overflow it
    fall    = dse_i && (mo == FALL_M) && (w == SUN_D) && (d + 7'd7 > mlen)
              && at_edge && !fb_done_i;
    day_c = 1'b0;
    if (spring) begin
      h = DST_H + 7'd2; m = '0; s = '0;
    end else if (fall) begin
      m = '0; s = '0;
    end else if (s >= 7'd59) begin
      s = '0;
      if (m >= 7'd59) begin
        m = '0;
        if (h >= 7'd23) begin h = '0; day_c = 1'b1; end
        else h = h + 7'd1;
      end else m = m + 7'd1;
    end else s = s + 7'd1;

    if (day_c) begin
      w = (w >= 7'd7) ? 7'd1 : w + 7'd1;
      if (d >= mlen) begin
        d = 7'd1;
        if (mo >= 7'd12) begin
          mo = 7'd1;
          y  = (y >= LAST_YEAR) ? 7'd0 : y + 7'd1;
        end else mo = mo + 7'd1;
      end else d = d + 7'd1;
    end

    nxt_o.sec  = enc_val(s, bin_i);
    nxt_o.min  = enc_val(m, bin_i);
    nxt_o.hour = hour_from24(h, bin_i, h24_i);
    nxt_o.dow  = enc_val(w, bin_i);
    nxt_o.date = enc_val(d, bin_i);
    nxt_o.mon  = enc_val(mo, bin_i);
    nxt_o.year = enc_val(y, bin_i);
    fb_set_o   = fall;
    fb_clr_o   = (h > DST_H);
  end

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
  parameter int N = 3
) (
  input  logic [N-1:0][7:0] alarm_i,
  input  logic [N-1:0][7:0] time_i,
  output logic              match_o
);
  logic [N-1:0] hit;

  for (genvar gi = 0; gi < N; gi++) begin : g_byte
    assign hit[gi] = (&alarm_i[gi][7:6]) || (alarm_i[gi] == time_i[gi]);
  end

  assign match_o = &hit;

endmodule

// File: rtl/rtc_cal_engine.sv
`timescale 1ns/1ps
module rtc_cal_engine
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              set_i,
  input  logic              bin_mode_i,
  input  logic              hour24_i,
  input  logic              dst_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              alarm_o,
  output logic              update_o
);
  localparam int N_TIME   = 7;
  localparam int N_ALM    = 3;
  localparam int ALM_BASE = N_TIME;
  localparam int IDX_W    = $clog2(N_TIME);
  localparam int AIDX_W   = $clog2(N_ALM);
  localparam logic [N_TIME-1:0][7:0] RST_TIME =
    {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  logic [N_TIME-1:0][7:0] int_q, usr_q, int_d, usr_d, nxt_arr;
  logic [N_ALM-1:0][7:0]  alm_q, alm_d;
  cal_t nxt_cal;
  logic fb_q, fb_set, fb_clr, match, xfer;
  logic upd_q, alm_hit_q;

  assign xfer    = tick_i && !set_i;
  assign nxt_arr = nxt_cal;

  rtc_cal_next u_next (
    .cur_i     (cal_t'(int_q)),
    .bin_i     (bin_mode_i),
    .h24_i     (hour24_i),
    .dse_i     (dst_en_i),
    .fb_done_i (fb_q),
    .nxt_o     (nxt_cal),
    .fb_set_o  (fb_set),
    .fb_clr_o  (fb_clr)
  );

  for (genvar gi = 0; gi < N_TIME; gi++) begin : g_time
    logic       hit;
    logic [7:0] wdat;
    assign hit  = wr_en_i && (wr_addr_i == ADDR_W'(gi));
    assign wdat = (gi == 0) ? {1'b0, wr_data_i[6:0]} : wr_data_i;
    assign int_d[gi] = hit ? wdat : tick_i ? nxt_arr[gi] : int_q[gi];
    assign usr_d[gi] = hit ? wdat : xfer   ? nxt_arr[gi] : usr_q[gi];
  end

  for (genvar gi = 0; gi < N_ALM; gi++) begin : g_alm
    assign alm_d[gi] = (wr_en_i && wr_addr_i == ADDR_W'(ALM_BASE + gi)) ? wr_data_i : alm_q[gi];
  end

  rtc_alarm_match #(.N(N_ALM)) u_match (
    .alarm_i (alm_q),
    .time_i  (nxt_arr[N_ALM-1:0]),
    .match_o (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q     <= RST_TIME;
      usr_q     <= RST_TIME;
      alm_q     <= '0;
      fb_q      <= 1'b0;
      upd_q     <= 1'b0;
      alm_hit_q <= 1'b0;
    end else begin
      int_q     <= int_d;
      usr_q     <= usr_d;
      alm_q     <= alm_d;
      upd_q     <= xfer;
      alm_hit_q <= xfer && match;
      if (tick_i) begin
        if (fb_set)      fb_q <= 1'b1;
        else if (fb_clr) fb_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(N_TIME))
      rd_data_o = usr_q[IDX_W'(rd_addr_i)];
    else if (rd_addr_i < ADDR_W'(N_TIME + N_ALM))
      rd_data_o = alm_q[AIDX_W'(rd_addr_i - ADDR_W'(ALM_BASE))];
  end

  assign update_o = upd_q;
  assign alarm_o  = alm_hit_q;

  AST_FROZEN_WHILE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wr_en_i) |=> $stable(usr_q)); // R7
  AST_WORK_COPY_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i) |=> (int_q != $past(int_q))); // R7
  AST_UPDATE_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(tick_i && !set_i)); // R10
  AST_ALARM_WITH_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> update_o); // R9
  AST_SEC_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !usr_q[0][7] && !int_q[0][7]); // R8

endmodule

// File: tb/rtc_cal_engine_test.sv
`timescale 1ns/1ps
module rtc_cal_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, set = 0, bin = 1, h24 = 1, dse = 0, wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic alarm, upd;

  always #2.5 clk = ~clk;

  rtc_cal_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .set_i(set),
    .bin_mode_i(bin), .hour24_i(h24), .dst_en_i(dse),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .alarm_o(alarm), .update_o(upd)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int ms, mm, mh, mw, md, mon, my;
  bit mfb = 0;
  int u[7];
  int ma[3];

  function automatic int enc(int v);
    return bin ? v : (v / 10) * 16 + v % 10;
  endfunction

  function automatic int enc_h(int h);
    int h12;
    if (h24) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return enc(h12) + (h >= 12 ? 128 : 0);
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_byte(int a);
    case (a)
      0: return enc(ms);
      1: return enc(mm);
      2: return enc_h(mh);
      3: return enc(mw);
      4: return enc(md);
      5: return enc(mon);
      default: return enc(my);
    endcase
  endfunction

  task automatic m_step();
    bit at1;
    at1 = (mh == 1 && mm == 59 && ms == 59);
    if (dse && mon == 4 && mw == 1 && md <= 7 && at1) begin
      mh = 3; mm = 0; ms = 0;
    end else if (dse && mon == 10 && mw == 1 && md + 7 > mlen(mon, my) && at1 && !mfb) begin
      mm = 0; ms = 0; mfb = 1;
    end else begin
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin
          mm = 0; mh++;
          if (mh == 24) begin
            mh = 0;
            mw = (mw == 7) ? 1 : mw + 1;
            if (md >= mlen(mon, my)) begin
              md = 1; mon++;
              if (mon == 13) begin mon = 1; my = (my + 1) % 100; end
            end else md++;
          end
        end
      end
    end
    if (mh > 1) mfb = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    rd_addr = 4'(a);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic check_all(string req);
    int v;
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check(req, $sformatf("byte %0d", a), v, u[a]);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic mode(bit b, bit h, bit d);
    @(negedge clk);
    bin = b; h24 = h; dse = d;
  endtask

  task automatic setc(bit v);
    @(negedge clk);
    set = v;
  endtask

  task automatic load(int s, int m, int h, int w, int d, int mo, int y);
    ms = s; mm = m; mh = h; mw = w; md = d; mon = mo; my = y;
    for (int a = 0; a < 7; a++) begin
      wr(a, exp_byte(a));
      u[a] = exp_byte(a);
    end
  endtask

  task automatic walm(int i, int v);
    wr(7 + i, v);
    ma[i] = v;
  endtask

  task automatic tick_chk(string req);
    bit hit;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    m_step();
    if (!set) for (int a = 0; a < 7; a++) u[a] = exp_byte(a);
    hit = !set;
    for (int i = 0; i < 3; i++)
      if (!(ma[i] >= 8'hC0 || ma[i] == exp_byte(i))) hit = 0;
    check(req, "update pulse", int'(upd), int'(!set));
    check(req, "alarm pulse", int'(alarm), int'(hit));
    check_all(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) ma[i] = 0;
    u = '{0, 0, 0, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset values
    check_all("R13");
    for (int i = 0; i < 3; i++) begin rd(7 + i, v); check("R13", "alarm byte", v, 0); end
    check("R13", "update after reset", int'(upd), 0);
    check("R13", "alarm after reset", int'(alarm), 0);

    // R1 R4 R5 R6 binary year end
    mode(1, 1, 0);
    load(59, 59, 23, 7, 31, 12, 99);
    tick_chk("R1 R4 R5 R6");
    @(negedge clk);
    check("R10", "update one cycle", int'(upd), 0);
    // R2 packed decimal year end
    mode(0, 1, 0);
    load(59, 59, 23, 7, 31, 12, 99);
    tick_chk("R2 R4 R5 R6");
    load(59, 59, 9, 3, 9, 9, 19);
    tick_chk("R2");
    // R5 month lengths
    mode(1, 1, 0);
    load(59, 59, 23, 2, 28, 2, 24); tick_chk("R5 leap");
    load(59, 59, 23, 2, 29, 2, 24); tick_chk("R5 leap end");
    load(59, 59, 23, 2, 28, 2, 23); tick_chk("R5 non-leap");
    mode(0, 1, 0);
    load(59, 59, 23, 5, 30, 4, 7);  tick_chk("R5 thirty");
    load(59, 59, 23, 5, 30, 5, 7);  tick_chk("R5 thirty-one");
    // R3 twelve-hour
    for (int b = 0; b < 2; b++) begin
      mode(b[0], 0, 0);
      load(59, 59, 11, 2, 5, 6, 30); tick_chk("R3 noon");
      load(59, 59, 12, 2, 5, 6, 30); tick_chk("R3 one pm");
      load(59, 59, 0, 2, 5, 6, 30);  tick_chk("R3 one am");
      load(59, 59, 23, 2, 5, 6, 30); tick_chk("R3 midnight");
    end
    // R7 hold
    mode(1, 1, 0);
    load(58, 59, 10, 4, 12, 8, 40);
    setc(1);
    repeat (3) tick_chk("R7 frozen");
    setc(0);
    tick_chk("R7 resume");
    // R8 seconds top bit, alarm readback, unmapped address
    wr(0, 8'hA5); ms = 37; u[0] = 8'h25;
    check_all("R8");
    tick_chk("R8");
    walm(0, 8'h12); walm(1, 8'h34); walm(2, 8'h56);
    for (int i = 0; i < 3; i++) begin rd(7 + i, v); check("R8", "alarm readback", v, ma[i]); end
    rd(12, v); check("R8", "unmapped read", v, 0);
    // R9 alarm
    load(10, 20, 5, 3, 3, 3, 3);
    walm(0, 11); walm(1, 20); walm(2, 5);
    tick_chk("R9 exact");
    tick_chk("R9 miss");
    walm(0, 8'hC0);
    tick_chk("R9 wild sec");
    walm(1, 8'hFF); walm(2, 8'hC7);
    tick_chk("R9 all wild");
    walm(2, 9);
    tick_chk("R9 hour miss");
    mode(0, 0, 0);
    load(44, 0, 13, 1, 1, 1, 1);
    walm(0, 8'h45); walm(1, 8'h00); walm(2, 8'h81);
    tick_chk("R9 decimal pm");
    // R11 spring
    mode(1, 1, 1);
    load(59, 59, 1, 1, 3, 4, 21); tick_chk("R11 forward");
    mode(1, 1, 0);
    load(59, 59, 1, 1, 3, 4, 21); tick_chk("R11 disabled");
    mode(0, 0, 1);
    load(59, 59, 1, 1, 7, 4, 21); tick_chk("R11 twelve-hour");
    // R12 autumn
    mode(1, 1, 1);
    load(59, 59, 1, 1, 28, 10, 18); tick_chk("R12 back");
    load(59, 59, 1, 1, 28, 10, 18); tick_chk("R12 once");
    load(59, 59, 1, 1, 28, 10, 18); tick_chk("R12 rearmed");
    load(59, 59, 1, 1, 21, 10, 18); tick_chk("R12 not last week");

    // random mix
    for (int it = 0; it < 150; it++) begin
      int s, m, h, w, d, mo, y;
      mode(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 3 == 0) ? 1 : int'($urandom % 24);
      w  = 1 + int'($urandom % 7);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = ($urandom % 2) ? mlen(mo, y) : 1 + int'($urandom % 28);
      load(s, m, h, w, d, mo, y);
      for (int i = 0; i < 3; i++) begin
        case ($urandom % 3)
          0: walm(i, 8'hC0 | int'($urandom % 64));
          1: walm(i, exp_byte(i));
          default: walm(i, enc(int'($urandom % 24)));
        endcase
      end
      repeat (1 + $urandom % 3) tick_chk("R1 R2 R3 R9 R12");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule